// File: doc/BRIEF.md
# Reconfigurable Fusion-Gate Cell Array

This block is a rectangular grid of small configurable logic cells. Each cell contains one fixed two-input, two-output primitive. The primitive takes a signal A travelling downward and a signal B travelling rightward. It sends A onward only when B is absent, and B onward only when A is absent. When both are present they cancel each other. Because the cell function is fixed, a cell is programmed only through its inputs and its routing. A cell can force its downward input to a constant, and it can open or close the switch on each of its two output sides. Signals only ever move down or to the right, so the grid has no combinational loops. The edge outputs settle in the same cycle as the edge inputs change.

Configuration is written a whole cell word at a time through a shift chain. The chain visits the cells in row-major order. While the load strobe is high, each clock moves every stored word one cell toward cell (0,0). The new word enters at the last cell. After ROWS*COLS strobed clocks, the first word written sits in cell (0,0). While loading is in progress, every edge output is held at 0. After reset, every cell holds an all-zero word, and an all-zero word blocks both outputs.

Top module: `fg_array`

## Requirements
- R1: Each cell computes down-out = A AND NOT B and right-out = NOT A AND B, where A is its effective top input and B is its left input.
- R2: When A and B are both 1, a cell emits 0 on both sides. When A and B are both 0, it also emits 0 on both sides.
- R3: Bit 0 of a cell word set to 1 replaces the cell's top input with the value of bit 1. With bits 0 and 1 both set, the down-out is the inverse of the left input.
- R4: Bit 2 of a cell word closes the down-side switch and bit 3 closes the right-side switch. An open switch delivers 0 to the neighbour below or to the right, or to the edge output.
- R5: On each clock with `cfg_load` high, cell k (k = row*COLS + col) takes the word of cell k+1, and the last cell takes `cfg_word`. With `cfg_load` low, every stored word is kept and `cfg_word` has no effect.
- R6: While `cfg_load` is high, `s_out` and `e_out` are all 0 whatever the edge inputs are.
- R7: During reset and after it, until a word is loaded, every cell word is 0 and all edge outputs are 0.
- R8: Row 0 takes its top inputs from `y_in[col]` and column 0 takes its left inputs from `x_in[row]`. The bottom row drives `s_out[col]` and the rightmost column drives `e_out[row]`. The outputs follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Shift strobe for the configuration chain; it also blanks the outputs |
| cfg_word | input | 4 | Cell word entering the last cell of the chain |
| x_in | input | ROWS | Left-edge inputs, one per row |
| y_in | input | COLS | Top-edge inputs, one per column |
| s_out | output | COLS | Bottom-edge outputs, one per column |
| e_out | output | ROWS | Right-edge outputs, one per row |

## Verification
The hardest case to reach from the ports is a signal that passes through several cells in series, each with its own forcing and switch settings. Only the full shift sequence can put a chosen word into an interior cell. The stimulus therefore loads complete grids: a uniform all-pass grid swept with every edge input combination, a column that implements an inverter, and several random grids. These are mixed with partial loads and with clocks where the load strobe is low and `cfg_word` keeps changing.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam int CFG_W = 4;

  typedef struct packed {
    logic east_pass;   // bit 3: right-side switch closed
    logic south_pass;  // bit 2: down-side switch closed
    logic north_val;   // bit 1: constant for the top input
    logic north_force; // bit 0: replace the top input by north_val
  } fg_cfg_t;
endpackage

// File: rtl/fg_rst_sync.sv
module fg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/fg_fuse.sv
module fg_fuse (
  input  logic a_in,
  input  logic b_in,
  output logic s_raw,
  output logic e_raw
);
  always_comb begin
    s_raw = a_in & ~b_in;
    e_raw = ~a_in & b_in;
  end
endmodule

// File: rtl/fg_cell.sv
module fg_cell
  import fg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  fg_cfg_t shift_in,
  output fg_cfg_t cfg_q,
  input  logic    north_in,
  input  logic    west_in,
  output logic    south_out,
  output logic    east_out
);
  fg_cfg_t cfg_d;
  logic    cfg_en;
  logic    a_eff;
  logic    s_raw;
  logic    e_raw;

  always_comb begin
    cfg_en = load;
    cfg_d  = shift_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  always_comb begin
    a_eff = cfg_q.north_force ? cfg_q.north_val : north_in;
  end

  fg_fuse u_fuse (
    .a_in (a_eff),
    .b_in (west_in),
    .s_raw(s_raw),
    .e_raw(e_raw)
  );

  always_comb begin
    south_out = ~load & cfg_q.south_pass & s_raw;
    east_out  = ~load & cfg_q.east_pass  & e_raw;
  end

  assert_annihilate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_eff && west_in) |-> (!s_raw && !e_raw));

  assert_invert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.north_force && cfg_q.north_val) |-> (s_raw == !west_in));

  assert_switch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.south_pass |-> !south_out) and (!cfg_q.east_pass |-> !east_out));

  assert_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cfg_q == $past(shift_in)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));
endmodule

// File: rtl/fg_array.sv
module fg_array
  import fg_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [ROWS-1:0]  x_in,
  input  logic [COLS-1:0]  y_in,
  output logic [COLS-1:0]  s_out,
  output logic [ROWS-1:0]  e_out
);
  localparam int NCELL = ROWS * COLS;

  logic    rst_n_int;
  fg_cfg_t cfg_all [NCELL];
  logic    n_net   [NCELL];
  logic    w_net   [NCELL];
  logic    s_net   [NCELL];
  logic    e_net   [NCELL];

  fg_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int K = r * COLS + c;
      fg_cfg_t chain_in;

      if (r == 0) begin : g_top
        assign n_net[K] = y_in[c];
      end else begin : g_inner_n
        assign n_net[K] = s_net[K-COLS];
      end

      if (c == 0) begin : g_left
        assign w_net[K] = x_in[r];
      end else begin : g_inner_w
        assign w_net[K] = e_net[K-1];
      end

      if (K == NCELL - 1) begin : g_tail
        assign chain_in = fg_cfg_t'(cfg_word);
      end else begin : g_link
        assign chain_in = cfg_all[K+1];
      end

      fg_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n_int),
        .load     (cfg_load),
        .shift_in (chain_in),
        .cfg_q    (cfg_all[K]),
        .north_in (n_net[K]),
        .west_in  (w_net[K]),
        .south_out(s_net[K]),
        .east_out (e_net[K])
      );
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_sedge
    assign s_out[c] = s_net[(ROWS-1)*COLS + c];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_eedge
    assign e_out[r] = e_net[r*COLS + COLS - 1];
  end

  assert_load_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    cfg_load |-> (s_out == '0 && e_out == '0));

  assert_reset_dark_R7: assert property (@(posedge clk)
    !rst_n_int |-> (s_out == '0 && e_out == '0));
endmodule

// File: tb/sim_fg_array.sv
module sim_fg_array;
  localparam int ROWS = 3;
  localparam int COLS = 4;
  localparam int N = ROWS * COLS;
  localparam int CLK_PERIOD = 10;

  logic            clk;
  logic            rst_n;
  logic            cfg_load;
  logic [3:0]      cfg_word;
  logic [ROWS-1:0] x_in;
  logic [COLS-1:0] y_in;
  logic [COLS-1:0] s_out;
  logic [ROWS-1:0] e_out;

  int vectors;
  int miscompares;
  logic [3:0] mcfg [N];

  fg_array #(.ROWS(ROWS), .COLS(COLS)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .x_in(x_in), .y_in(y_in), .s_out(s_out), .e_out(e_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: walk the grid, then gate by the load strobe.
  task automatic model_eval(input logic ld, input logic [ROWS-1:0] xv,
                            input logic [COLS-1:0] yv,
                            output logic [COLS-1:0] se, output logic [ROWS-1:0] ee);
    logic down [N];
    logic right [N];
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int k;
        logic a, b;
        k = r * COLS + c;
        a = (r == 0) ? yv[c] : down[k-COLS];
        b = (c == 0) ? xv[r] : right[k-1];
        if (mcfg[k][0]) a = mcfg[k][1];
        down[k]  = mcfg[k][2] && !ld && (a && !b);
        right[k] = mcfg[k][3] && !ld && (!a && b);
      end
    end
    for (int c = 0; c < COLS; c++) se[c] = down[(ROWS-1)*COLS + c];
    for (int r = 0; r < ROWS; r++) ee[r] = right[r*COLS + COLS - 1];
  endtask

  task automatic step(input logic ld, input logic [3:0] w,
                      input logic [ROWS-1:0] xv, input logic [COLS-1:0] yv,
                      input string tag);
    logic [COLS-1:0] se;
    logic [ROWS-1:0] ee;
    @(negedge clk);
    cfg_load = ld; cfg_word = w; x_in = xv; y_in = yv;
    #1;
    model_eval(ld, xv, yv, se, ee);
    vectors++;
    if (s_out !== se || e_out !== ee) begin
      miscompares++;
      $display("FAIL %s: s_out=%b e_out=%b expected s_out=%b e_out=%b",
               tag, s_out, e_out, se, ee);
    end
    @(posedge clk);
    if (ld && rst_n) begin
      for (int k = 0; k < N - 1; k++) mcfg[k] = mcfg[k+1];
      mcfg[N-1] = w;
    end
  endtask

  task automatic load_grid(input logic [3:0] words [N]);
    for (int k = 0; k < N; k++)
      step(1'b1, words[k], ROWS'($urandom), COLS'($urandom), "R6 R5");
  endtask

  task automatic random_vectors(input int n, input string tag);
    for (int i = 0; i < n; i++)
      step(1'b0, 4'($urandom), ROWS'($urandom), COLS'($urandom), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [3:0] g [N];
    vectors = 0; miscompares = 0;
    for (int k = 0; k < N; k++) mcfg[k] = 4'h0;
    rst_n = 1'b0; cfg_load = 1'b0; cfg_word = 4'h0; x_in = '0; y_in = '0;

    // R7: reset and the idle cycles after its synchronous release
    for (int i = 0; i < 4; i++) step(1'b0, 4'hF, ROWS'($urandom), COLS'($urandom), "R7");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 4'hF, ROWS'($urandom), COLS'($urandom), "R7");

    // R1 R2 R8: all-pass grid, every edge input combination
    for (int k = 0; k < N; k++) g[k] = 4'b1100;
    load_grid(g);
    for (int v = 0; v < (1 << (ROWS + COLS)); v++)
      step(1'b0, 4'($urandom), ROWS'(v), COLS'(v >> ROWS), "R1 R2 R8");

    // R3: forced top input at cell (0,0), column 0 passes downward
    for (int k = 0; k < N; k++) g[k] = 4'b0000;
    g[0] = 4'b0111;
    for (int r = 1; r < ROWS; r++) g[r*COLS] = 4'b0100;
    load_grid(g);
    step(1'b0, 4'h0, '0, COLS'($urandom), "R3");
    step(1'b0, 4'h0, ROWS'(1), COLS'($urandom), "R3");
    random_vectors(12, "R3");

    // R4 R5: random grids with held configuration and changing cfg_word
    for (int round = 0; round < 4; round++) begin
      for (int k = 0; k < N; k++) g[k] = 4'($urandom);
      load_grid(g);
      random_vectors(24, "R4 R5");
    end

    // R5: partial load moves earlier words only part of the way
    for (int k = 0; k < 5; k++)
      step(1'b1, 4'($urandom) | 4'b1100, ROWS'($urandom), COLS'($urandom), "R6 R5");
    random_vectors(24, "R5");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule